// File: doc/BRIEF.md
# Reversible Galois LFSR Counter

This block is an n-bit counter built from a linear feedback shift register in Galois form with XNOR feedback. The binary value of the count has no meaning. What matters is that the register moves through a fixed maximum-length sequence, and that it can move forward or backward along that same sequence under a direction input. Every bit has a small 2-to-1 multiplexer that picks the forward or the backward next value. Each direction has its own set of XNOR taps: forward steps use a primitive polynomial g(x), and backward steps use its reciprocal. A backward step therefore exactly undoes the forward step before it.

Each step costs one flop, one XNOR and the feedback wire, whatever the width. There is no carry chain. A zero detector reports whether the register sits at its reset code, which is all zeros. This lets the counter serve as a compact occupancy counter where only "zero or not" is ever asked.

Top module: `updn_lfsr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes all zeros and `is_zero` reads 1 after that edge.
- R2: With `rst` low and `en` low, the state keeps its value across the edge, whatever `up` is.
- R3: With `rst` low, `en` high and `up` = 1 (forward), the new bit 0 equals the old bit n-1. Each bit i (1..n-1) whose coefficient c_i in g(x) is 1 becomes XNOR(old bit i-1, old bit n-1). Every other bit takes the old bit i-1.
- R4: With `en` high and `up` = 0 (backward), the step is the exact inverse of R3. The new bit n-1 equals the old bit 0. Bit j (0..n-2) becomes XNOR(old bit j+1, old bit 0) when c_{j+1} = 1, and otherwise takes old bit j+1. A forward step followed by a backward step restores the earlier state.
- R5: Starting from reset, the state first returns to all zeros after exactly 2^n - 1 steps, in either direction.
- R6: The all-ones code, the XNOR lock-up state, is never reached from reset.
- R7: `is_zero` is 1 exactly when the state is all zeros.
- R8: The forward polynomials per width are: 3: x^3+x^2+1; 4: x^4+x^3+1; 5: x^5+x^3+1; 6: x^6+x^5+1; 7: x^7+x^6+1; 8: x^8+x^6+x^5+x^4+1; 16: x^16+x^14+x^13+x^11+1.
- R9: `rst` takes priority over `en` and `up`.
- R10: Any enabled step taken from the all-zeros state leaves it, so `is_zero` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to all zeros |
| en | input | 1 | Step enable |
| up | input | 1 | Direction: 1 forward, 0 backward |
| state | output | WIDTH | Current register contents |
| is_zero | output | 1 | High when state is all zeros |

## Verification
The assertions assume that `rst` is held for at least one edge before any step. They also assume that the width is one of the tabled values, so the taps form a primitive polynomial and the no-lock-up and leave-zero properties hold. The bench starts every run from reset. It only instantiates widths 3, 8 and 16, and it drives `en`, `up` and `rst` away from the rising edge. This keeps every step inside the sequence the assertions expect.

// File: rtl/updn_lfsr_pkg.sv
package updn_lfsr_pkg;

  // Forward coefficients c_1..c_(n-1) of g(x), as a bit mask (bit i = c_i).
  function automatic logic [31:0] up_tap_mask(input int width);
    logic [31:0] m;
    case (width)
      3:  m = 32'h0000_0004;
      4:  m = 32'h0000_0008;
      5:  m = 32'h0000_0008;
      6:  m = 32'h0000_0020;
      7:  m = 32'h0000_0040;
      8:  m = 32'h0000_0070;
      16: m = 32'h0000_6800;
      default: m = 32'h0;
    endcase
    return m;
  endfunction

  // Backward tap at bit j is the forward coefficient c_(j+1) (reciprocal).
  function automatic logic dn_tap(input logic [31:0] upmask, input int j, input int width);
    return (j < width - 1) ? upmask[j+1] : 1'b0;
  endfunction

  function automatic logic up_tap(input logic [31:0] upmask, input int i);
    return (i > 0) ? upmask[i] : 1'b0;
  endfunction

endpackage

// File: rtl/updn_lfsr_cell.sv
module updn_lfsr_cell #(
  parameter bit TAP_UP = 1'b0,
  parameter bit TAP_DN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic up,
  input  logic from_lo,
  input  logic from_hi,
  input  logic fb_up,
  input  logic fb_dn,
  output logic q
);
  logic nxt_up, nxt_dn, nxt;

  generate
    if (TAP_UP) begin : g_up_tap
      assign nxt_up = ~(from_lo ^ fb_up);
    end else begin : g_up_pass
      assign nxt_up = from_lo;
    end
    if (TAP_DN) begin : g_dn_tap
      assign nxt_dn = ~(from_hi ^ fb_dn);
    end else begin : g_dn_pass
      assign nxt_dn = from_hi;
    end
  endgenerate

  assign nxt = up ? nxt_up : nxt_dn;

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/updn_lfsr_zero.sv
module updn_lfsr_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);
  logic [WIDTH-1:0] seen_one;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_slice
      if (k == 0) begin : g_first
        assign seen_one[k] = vec[k];
      end else begin : g_rest
        assign seen_one[k] = seen_one[k-1] | vec[k];
      end
    end
  endgenerate

  assign all_zero = ~seen_one[WIDTH-1];
endmodule

// File: rtl/updn_lfsr_counter.sv
module updn_lfsr_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             up,
  output logic [WIDTH-1:0] state,
  output logic             is_zero
);
  import updn_lfsr_pkg::*;

  localparam logic [31:0] UP_MASK = up_tap_mask(WIDTH);
  localparam int          MSB     = WIDTH - 1;

  logic [WIDTH-1:0] s;
  logic             fb_up, fb_dn;

  assign fb_up = s[MSB];
  assign fb_dn = s[0];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic lo_src, hi_src;
      if (i == 0) begin : g_lo_wrap
        assign lo_src = s[MSB];
      end else begin : g_lo_shift
        assign lo_src = s[i-1];
      end
      if (i == MSB) begin : g_hi_wrap
        assign hi_src = s[0];
      end else begin : g_hi_shift
        assign hi_src = s[i+1];
      end
      updn_lfsr_cell #(
        .TAP_UP(up_tap(UP_MASK, i)),
        .TAP_DN(dn_tap(UP_MASK, i, WIDTH))
      ) u_cell (
        .clk(clk), .rst(rst), .en(en), .up(up),
        .from_lo(lo_src), .from_hi(hi_src),
        .fb_up(fb_up), .fb_dn(fb_dn),
        .q(s[i])
      );
    end
  endgenerate

  updn_lfsr_zero #(.WIDTH(WIDTH)) u_zero (.vec(s), .all_zero(is_zero));

  assign state = s;

  // Named events for the checks below.
  logic             step_fwd, step_bwd;
  logic             fwd_q;
  logic [WIDTH-1:0] before_q;

  assign step_fwd = !rst && en && up;
  assign step_bwd = !rst && en && !up;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q    <= 1'b0;
      before_q <= '0;
    end else begin
      fwd_q    <= step_fwd;
      before_q <= s;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> (state == '0 && is_zero));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(state));
  assert_undo_R4: assert property (@(posedge clk) disable iff (rst)
    (fwd_q && step_bwd) |=> state == $past(before_q));
  assert_no_lockup_R6: assert property (@(posedge clk) disable iff (rst) state != '1);
  assert_leave_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (is_zero && en) |=> !is_zero);
  assert_step_moves_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> state != $past(state));
endmodule

// File: tb/updn_lfsr_counter_test.sv
`timescale 1ns/1ps
module updn_lfsr_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, up = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  st3;
  logic [7:0]  st8;
  logic [15:0] st16;
  logic z3, z8, z16;

  updn_lfsr_counter #(.WIDTH(3))  uut3  (.clk(clk), .rst(rst), .en(en), .up(up), .state(st3),  .is_zero(z3));
  updn_lfsr_counter #(.WIDTH(8))  uut   (.clk(clk), .rst(rst), .en(en), .up(up), .state(st8),  .is_zero(z8));
  updn_lfsr_counter #(.WIDTH(16)) uut16 (.clk(clk), .rst(rst), .en(en), .up(up), .state(st16), .is_zero(z16));

  int errors = 0, checks = 0;
  int m3 = 0, m8 = 0, m16 = 0;
  bit done = 0;

  // Full polynomial without x^n term (R8), used as multiply-by-x modulo g.
  function automatic int poly(int w);
    case (w)
      3: return 5;
      8: return 113;
      default: return 26625;
    endcase
  endfunction

  // Model works on the complemented value, where XNOR feedback becomes x-multiplication.
  function automatic int model_next(int w, int s, bit fwd);
    int mask = (1 << w) - 1;
    int t = (~s) & mask;
    int m;
    if (fwd) begin
      m = (t >> (w - 1)) & 1;
      t = ((t << 1) & mask) ^ (m ? poly(w) : 0);
    end else begin
      m = t & 1;
      t = ((t ^ (m ? poly(w) : 0)) >> 1) | (m << (w - 1));
    end
    return (~t) & mask;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, st3, m3);   check({req, "/R7"}, z3, m3 == 0);
    check(req, st8, m8);   check({req, "/R7"}, z8, m8 == 0);
    check(req, st16, m16); check({req, "/R7"}, z16, m16 == 0);
  endtask

  task automatic tick(bit e, bit u, bit r, string req);
    en = e; up = u; rst = r;
    @(posedge clk);
    if (r) begin m3 = 0; m8 = 0; m16 = 0; end
    else if (e) begin
      m3 = model_next(3, m3, u); m8 = model_next(8, m8, u); m16 = model_next(16, m16, u);
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f3, f8, f16, keep;
    @(negedge clk);
    repeat (3) tick(0, 1, 1, "R1");
    // R2: disabled with direction toggling
    for (int k = 0; k < 6; k++) tick(0, k[0], 0, "R2");
    // R3/R4: mixed enabled steps
    for (int k = 0; k < 400; k++) tick($urandom_range(0, 3) != 0, $urandom_range(0, 1), 0, "R3/R4");
    // R4: forward then backward restores
    for (int k = 0; k < 20; k++) begin
      keep = st8;
      tick(1, 1, 0, "R3");
      tick(1, 0, 0, "R4");
      check("R4 undo", st8, keep);
      tick(1, $urandom_range(0, 1), 0, "R3/R4");
    end
    // R9: reset wins over enable
    tick(1, 1, 1, "R9");
    check("R9", st16, 0);
    tick(1, 0, 1, "R9");
    // R10: leaving zero in both directions
    tick(1, 0, 0, "R10");
    check("R10", z8, 0);
    tick(0, 0, 1, "R1");
    // R5/R6: forward period
    f3 = 0; f8 = 0; f16 = 0;
    for (int k = 1; k <= 65535; k++) begin
      tick(1, 1, 0, "R5");
      if (st3 == 7 || st8 == 255 || st16 == 65535) check("R6", 1, 0);
      if (st3 == 0 && f3 == 0) f3 = k;
      if (st8 == 0 && f8 == 0) f8 = k;
      if (st16 == 0 && f16 == 0) f16 = k;
    end
    check("R5 fwd w3", f3, 7);
    check("R5 fwd w8", f8, 255);
    check("R5 fwd w16", f16, 65535);
    // R5: backward period
    tick(0, 0, 1, "R1");
    f3 = 0; f8 = 0; f16 = 0;
    for (int k = 1; k <= 65535; k++) begin
      tick(1, 0, 0, "R5");
      if (st3 == 7 || st8 == 255 || st16 == 65535) check("R6", 1, 0);
      if (st3 == 0 && f3 == 0) f3 = k;
      if (st8 == 0 && f8 == 0) f8 = k;
      if (st16 == 0 && f16 == 0) f16 = k;
    end
    check("R5 bwd w3", f3, 7);
    check("R5 bwd w8", f8, 255);
    check("R5 bwd w16", f16, 65535);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule